// File: doc/BRIEF.md
# Serial Receive Channel with Sticky Error Flags

This block receives asynchronous serial frames from a single line and offers them to software through a few register-style strobes. The line idles high. A frame is one start bit, eight data bits with the least significant bit first, an optional parity bit and one stop bit. The block times each bit with a 16x oversampling tick from an external rate generator. It samples each bit near its middle. A start bit only counts if the line is still low at the midpoint of that bit.

The received byte goes into a one-entry buffer, and a buffer-full flag marks it. Reading the data register frees the buffer. Three sticky error flags report problems: parity, framing and overrun. Reading them does not clear them. Software clears a flag by writing a mask to a separate clear strobe. The mask uses the same bit positions as the status vector, so writing back the value just read clears exactly the flags that were set.

Two trigger strobes drive a channel-enable bit, one to start the channel and one to stop it. A framing error is taken to mean that start-bit alignment has been lost. The receiver then ignores the line until software stops the channel and starts it again. After the restart it waits for a fresh start bit.

Top module: `uart_rx_chan`

## Requirements
- R1: After reset, chan_en, buf_full and all three err_flags bits are 0 and rx_data is 0.
- R2: A start_trig pulse sets chan_en to 1 at the next clock edge and a stop_trig pulse sets it to 0. When both pulse in the same cycle, stop wins. While chan_en is 0, activity on the line has no effect on buf_full, rx_data or err_flags.
- R3: A frame with a valid stop bit (line 1 at the stop-bit midpoint) that arrives while the buffer is empty is stored. The first data bit lands in rx_data bit 0 and buf_full becomes 1.
- R4: When par_en is 1, a parity bit follows the data bits. For even parity (par_odd=0) the expected bit is the XOR of the data bits, and for odd parity it is the inverse of that. A mismatch on a frame with a valid stop bit sets err_flags[2], and the byte is still stored when the buffer is empty. A matching bit sets no flag.
- R5: A 0 sampled at the stop-bit midpoint sets err_flags[1], and the byte is discarded. Later frames are ignored until a stop_trig and then a start_trig. After that restart, frames are received again.
- R6: A frame with a valid stop bit that completes while buf_full is 1 sets err_flags[0]. The previously buffered byte stays on rx_data and buf_full stays 1.
- R7: A data_rd pulse clears buf_full at the next clock edge, and the next frame is then stored normally.
- R8: Error flags stay set with no clear write. A clr_wr pulse clears each flag whose clr_mask bit is 1 and leaves the others, so writing back err_flags unchanged clears exactly the set flags.
- R9: When a clear write hits a flag in the same cycle as a new event for that flag, the flag is set.
- R10: A low pulse on the line that is high again before the start-bit midpoint is rejected, and no byte is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| par_en | input | 1 | 1: frame carries a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| start_trig | input | 1 | Start trigger strobe |
| stop_trig | input | 1 | Stop trigger strobe |
| data_rd | input | 1 | Data register read strobe |
| clr_wr | input | 1 | Clear register write strobe |
| clr_mask | input | 3 | Clear mask: bit 0 overrun, bit 1 framing, bit 2 parity |
| rx_data | output | 8 | Last stored byte |
| buf_full | output | 1 | Buffer holds an unread byte |
| err_flags | output | 3 | Sticky flags: bit 0 overrun, bit 1 framing, bit 2 parity |
| chan_en | output | 1 | Channel enable status |

## Verification
Register-side results appear at the first clock edge after the strobe: chan_en after a trigger, buf_full after a read, and the flags after a clear. The bench therefore samples them two cycles later on a falling edge. Frame results are due about four clocks after the stop-bit midpoint: two synchronizer stages, the completion register and the status update. That is roughly half a bit time before the frame's stop bit ends, so the bench queues its expectation 20 clocks after the last bit has been driven. The held-clear check for R9 watches err_flags on every edge of the frame, because the collision cycle cannot be picked out from the ports.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_LOST
  } rx_state_t;

  localparam int FLAG_OVR = 0;
  localparam int FLAG_FRM = 1;
  localparam int FLAG_PAR = 2;
  localparam int NFLAG    = 3;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] done_byte,
  output logic          done_par_bad,
  output logic          done_stop_bad
);
  localparam int CW  = $clog2(OSR);
  localparam int IW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int MID = OSR / 2 - 1;

  function automatic logic expected_par(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  rx_state_t     st;
  logic [CW-1:0] tcnt;
  logic [IW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          parbit;
  logic          rx_meta, rx_s;

  // named events for checks
  logic mid_tick, end_tick;
  assign mid_tick = tick && (tcnt == CW'(MID));
  assign end_tick = tick && (tcnt == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      tcnt          <= '0;
      bidx          <= '0;
      shreg         <= '0;
      parbit        <= 1'b0;
      done          <= 1'b0;
      done_byte     <= '0;
      done_par_bad  <= 1'b0;
      done_stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st   <= S_IDLE;
        tcnt <= '0;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st   <= S_START;
            tcnt <= '0;
          end
          S_START: if (mid_tick) begin
            tcnt <= '0;
            bidx <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else tcnt <= tcnt + 1'b1;
          S_DATA: if (end_tick) begin
            tcnt  <= '0;
            shreg <= {rx_s, shreg[DW-1:1]};
            bidx  <= bidx + 1'b1;
            if (bidx == IW'(DW - 1)) st <= par_en ? S_PAR : S_STOP;
          end else tcnt <= tcnt + 1'b1;
          S_PAR: if (end_tick) begin
            tcnt   <= '0;
            parbit <= rx_s;
            st     <= S_STOP;
          end else tcnt <= tcnt + 1'b1;
          S_STOP: if (end_tick) begin
            tcnt          <= '0;
            done          <= 1'b1;
            done_byte     <= shreg;
            done_par_bad  <= par_en && (parbit != expected_par(shreg, par_odd));
            done_stop_bad <= !rx_s;
            st            <= rx_s ? S_IDLE : S_LOST;
          end else tcnt <= tcnt + 1'b1;
          default: st <= S_LOST;
        endcase
      end
    end
  end

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == S_IDLE && !done));
  // R3
  frame_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == S_STOP));
  // R5
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOST && en) |=> (st == S_LOST && !done));
  // R10
  start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && mid_tick && rx_s && en) |=> (st == S_IDLE));
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [DW-1:0]    done_byte,
  input  logic             done_par_bad,
  input  logic             done_stop_bad,
  input  logic             data_rd,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             start_trig,
  input  logic             stop_trig,
  output logic [DW-1:0]    data_q,
  output logic             buf_full,
  output logic [NFLAG-1:0] flags,
  output logic             chan_en
);
  logic             good_frame, load, ovr_evt, par_evt, frm_evt;
  logic [NFLAG-1:0] evt, clr_eff;

  assign good_frame = done && !done_stop_bad;
  assign load       = good_frame && (!buf_full || data_rd);
  assign ovr_evt    = good_frame && buf_full && !data_rd;
  assign par_evt    = good_frame && done_par_bad;
  assign frm_evt    = done && done_stop_bad;

  always_comb begin
    evt           = '0;
    evt[FLAG_OVR] = ovr_evt;
    evt[FLAG_FRM] = frm_evt;
    evt[FLAG_PAR] = par_evt;
    clr_eff       = clr_wr ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      buf_full <= 1'b0;
      flags    <= '0;
      chan_en  <= 1'b0;
    end else begin
      if (load) begin
        data_q   <= done_byte;
        buf_full <= 1'b1;
      end else if (data_rd) begin
        buf_full <= 1'b0;
      end
      flags <= (flags & ~clr_eff) | evt;
      if (stop_trig)       chan_en <= 1'b0;
      else if (start_trig) chan_en <= 1'b1;
    end
  end

  // R6
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(buf_full && !data_rd) |-> $stable(data_q));
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !done) |=> $stable(flags));
  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> !chan_en);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[i] && !evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rxd,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             start_trig,
  input  logic             stop_trig,
  input  logic             data_rd,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [DW-1:0]    rx_data,
  output logic             buf_full,
  output logic [NFLAG-1:0] err_flags,
  output logic             chan_en
);
  logic          done, done_par_bad, done_stop_bad;
  logic [DW-1:0] done_byte;

  uart_rx_sampler #(.OSR(OSR), .DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .tick(tick16), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .done(done), .done_byte(done_byte),
    .done_par_bad(done_par_bad), .done_stop_bad(done_stop_bad)
  );

  uart_rx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .done(done), .done_byte(done_byte),
    .done_par_bad(done_par_bad), .done_stop_bad(done_stop_bad),
    .data_rd(data_rd), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .start_trig(start_trig), .stop_trig(stop_trig), .data_q(rx_data),
    .buf_full(buf_full), .flags(err_flags), .chan_en(chan_en)
  );
endmodule

// File: tb/tb_uart_rx_chan.sv
`timescale 1ns/1ps
module tb_uart_rx_chan;
  localparam int BITCLK = 64;  // 16 ticks x 4 clocks

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, start_trig = 1'b0, stop_trig = 1'b0;
  logic data_rd = 1'b0, clr_wr = 1'b0;
  logic [2:0] clr_mask = 3'b000;
  logic [7:0] rx_data;
  logic buf_full, chan_en;
  logic [2:0] err_flags;

  always #2.5 clk = ~clk;

  logic [1:0] tdiv = 2'd0;
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_rx_chan dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .start_trig(start_trig), .stop_trig(stop_trig),
    .data_rd(data_rd), .clr_wr(clr_wr), .clr_mask(clr_mask), .rx_data(rx_data),
    .buf_full(buf_full), .err_flags(err_flags), .chan_en(chan_en)
  );

  typedef struct {
    logic [7:0] data;
    logic       full;
    logic [2:0] flags;
    logic       en;
    string      req;
  } exp_t;

  exp_t q[$];
  int total = 0, passed = 0;
  logic [7:0] m_data = 8'h00;
  logic m_full = 1'b0, m_en = 1'b0;
  logic [2:0] m_flags = 3'b000;
  bit seen_ovr = 1'b0, watch_ovr = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({rx_data, buf_full, err_flags, chan_en} == {e.data, e.full, e.flags, e.en},
          e.req, "data/full/flags/en",
          {3'b0, rx_data, buf_full, err_flags, chan_en},
          {3'b0, e.data, e.full, e.flags, e.en});
    end
    if (watch_ovr && err_flags[0]) seen_ovr = 1'b1;
  end

  task automatic expect_now(input string req);
    exp_t e;
    e.data = m_data; e.full = m_full; e.flags = m_flags; e.en = m_en; e.req = req;
    q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk); clr_mask = m; clr_wr = 1'b1;
    @(negedge clk); clr_wr = 1'b0; clr_mask = 3'b000;
    @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit wpar, input bit pbit,
                            input bit stopv);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (wpar) drive_bit(pbit);
    drive_bit(stopv);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    chk(1'b0, "WATCHDOG", "timeout", 16'd0, 16'd1);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R1");

    // R2: frame while disabled is ignored
    send_frame(8'h5A, 0, 0, 1);
    expect_now("R2");
    pulse(start_trig); m_en = 1'b1;
    expect_now("R2");

    // R3: plain frame
    send_frame(8'hA5, 0, 0, 1);
    m_data = 8'hA5; m_full = 1'b1;
    expect_now("R3");

    // R6: overrun keeps old byte
    send_frame(8'h3C, 0, 0, 1);
    m_flags = 3'b001;
    expect_now("R6");

    // R8: flag persists, then write-back clears it
    repeat (100) @(negedge clk);
    expect_now("R8");
    clear(err_flags); m_flags = 3'b000;
    expect_now("R8");

    // R7: read frees buffer, next byte stored
    pulse(data_rd); m_full = 1'b0;
    expect_now("R7");
    send_frame(8'h3C, 0, 0, 1);
    m_data = 8'h3C; m_full = 1'b1;
    expect_now("R7");
    pulse(data_rd); m_full = 1'b0;

    // R4: even parity correct, then odd parity wrong
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h81, 1, ^8'h81, 1);
    m_data = 8'h81; m_full = 1'b1;
    expect_now("R4");
    pulse(data_rd); m_full = 1'b0;
    par_odd = 1'b1;
    send_frame(8'h47, 1, ^8'h47, 1);  // odd expects inverse of XOR
    m_data = 8'h47; m_full = 1'b1; m_flags = 3'b100;
    expect_now("R4");
    clear(3'b001); // mask without the parity bit leaves it set
    expect_now("R8");
    clear(err_flags); m_flags = 3'b000;
    expect_now("R8");
    pulse(data_rd); m_full = 1'b0;
    par_en = 1'b0;

    // R10: short glitch rejected
    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (700) @(negedge clk);
    expect_now("R10");

    // R5: framing error, lockout, restart
    send_frame(8'h99, 0, 0, 0);
    m_flags = 3'b010;
    expect_now("R5");
    send_frame(8'h12, 0, 0, 1);
    expect_now("R5");
    pulse(stop_trig); m_en = 1'b0;
    expect_now("R2");
    pulse(start_trig); m_en = 1'b1;
    send_frame(8'h6E, 0, 0, 1);
    m_data = 8'h6E; m_full = 1'b1;
    expect_now("R5");

    // R2: start and stop together, stop wins
    @(negedge clk); start_trig = 1'b1; stop_trig = 1'b1;
    @(negedge clk); start_trig = 1'b0; stop_trig = 1'b0;
    @(negedge clk); m_en = 1'b0;
    expect_now("R2");
    pulse(start_trig); m_en = 1'b1;

    // R9: clear held on overrun bit through an overrun frame
    clear(3'b010); m_flags = 3'b000;
    @(negedge clk); clr_mask = 3'b001; clr_wr = 1'b1; watch_ovr = 1'b1;
    send_frame(8'hF0, 0, 0, 1);
    watch_ovr = 1'b0; clr_wr = 1'b0; clr_mask = 3'b000;
    repeat (2) @(negedge clk);
    chk(seen_ovr, "R9", "overrun flag seen under clear", {15'b0, seen_ovr}, 16'd1);
    expect_now("R9");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule